// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic datapath of a small 8-bit accumulator controller, together with the register that holds its three condition flags: zero (Z), auxiliary carry (AC) and carry (CY). The instruction sequencer drives an operation code and the operands. The block then returns a byte result or a word result in the same cycle, with one write strobe for each width. The flag register loads its next value at the clock edge on which `op_en` is high. The result is combinational, so there is no data stream and no back-pressure. The sequencer keeps the operands and `op_en` steady for the whole cycle in which it wants the operation to take effect.

Each class of operation updates the flags in its own way. A byte compare and the word add, subtract and compare update all three flags. Byte increment and decrement keep CY. Rotates change only CY. Register-pair increment and decrement change no flag. Bit set and clear change no flag unless their target is the flag byte. Three direct operations set, clear or invert the carry.

The flag byte has Z at bit 6, AC at bit 4 and CY at bit 0. Every other bit position has no storage: it reads as 0, and writes to it are lost. Z is set when the result is zero. AC is the carry or borrow across bit 3; word operations take it from the low byte. CY is the carry out of the top bit, or the borrow when the subtrahend is greater than the minuend as unsigned values.

Top module: `acc8_alu`

## Requirements
- R1: After reset all three flags read 0. In a cycle with `op_en` low the flags keep their values at the next edge.
- R2: CMP forms acc_in minus opnd_in and sets Z, AC and CY from that difference. It raises neither write strobe.
- R3: INC and DEC return opnd_in plus or minus 1, modulo 256, and raise wr_byte. They update Z and AC (carry or borrow across bit 3) and keep CY.
- R4: ROR returns acc_in rotated right by one, with old bit 0 going to both bit 7 and CY. ROL rotates left, with old bit 7 going to both bit 0 and CY. Z and AC stay unchanged.
- R5: RORC shifts right through the carry: old CY goes to bit 7 and old bit 0 goes to CY. ROLC shifts left through the carry: old CY goes to bit 0 and old bit 7 goes to CY. Z and AC stay unchanged.
- R6: ADDW and SUBW return pair_in plus or minus imm_in, modulo 65536, and raise wr_word. CY is the carry out of bit 15, or the borrow. Z is set when the 16-bit result is zero. AC is the carry or borrow across bit 3.
- R7: CMPW sets the flags exactly as SUBW would, but raises neither write strobe.
- R8: INCW and DECW return pair_in plus or minus 1, wrapping at 16 bits, and raise wr_word. All flags stay unchanged.
- R9: BSET and BCLR return opnd_in with bit bit_sel forced to 1 or to 0, and raise wr_byte. All flags stay unchanged.
- R10: FSET and FCLR force bit bit_sel of the flag byte to 1 or to 0. The flag byte has Z at bit 6, AC at bit 4 and CY at bit 0. Selecting any other bit changes no flag.
- R11: CSET sets CY, CCLR clears CY and CNOT inverts CY. Z and AC stay unchanged.
- R12: wr_byte and wr_word are never high together. Both are low while op_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Execute the operation and load the flags at this edge |
| op_code | input | 5 | Operation, encoded as `alu_op_e` in the package |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second byte operand |
| pair_in | input | 16 | Register-pair operand |
| imm_in | input | 16 | Immediate word |
| bit_sel | input | 3 | Bit index for the bit operations |
| res_byte | output | 8 | Byte result |
| res_word | output | 16 | Word result |
| wr_byte | output | 1 | Byte result is to be written |
| wr_word | output | 1 | Word result is to be written |
| flag_z | output | 1 | Registered zero flag |
| flag_ac | output | 1 | Registered auxiliary carry flag |
| flag_cy | output | 1 | Registered carry flag |

## Verification
The hardest cases to reach are the ones in which a flag must survive an operation. An example is an increment that wraps to zero while CY is already 1. Another is a rotate that must leave a Z of 1 in place. The bench first puts the flag register into a known, deliberately unusual state with the carry and flag-byte operations. It then runs the operation under test and checks that the untouched flags still match. Flag-byte writes to bit positions without storage are checked the same way, by reading all three flags afterwards.

// File: rtl/acc8_alu_pkg.sv
package acc8_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 5;
  localparam int SEL_W  = $clog2(BYTE_W);
  localparam int FB_Z   = 6;
  localparam int FB_AC  = 4;
  localparam int FB_CY  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_CMP, OP_INC, OP_DEC, OP_ROR, OP_ROL, OP_RORC, OP_ROLC,
    OP_ADDW, OP_SUBW, OP_CMPW, OP_INCW, OP_DECW, OP_BSET, OP_BCLR,
    OP_FSET, OP_FCLR, OP_CSET, OP_CCLR, OP_CNOT
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic ac;
    logic cy;
  } flags_t;

  function automatic logic is_word_op(alu_op_e op);
    return op inside {OP_ADDW, OP_SUBW, OP_CMPW, OP_INCW, OP_DECW};
  endfunction
endpackage

// File: rtl/acc8_byte_unit.sv
module acc8_byte_unit
  import acc8_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] opnd,
  input  logic [SEL_W-1:0]  bsel,
  input  flags_t            fin,
  output logic [BYTE_W-1:0] res,
  output flags_t            fout,
  output logic              wr
);
  logic [BYTE_W:0]   diff;
  logic [NIB_W:0]    ndiff;
  logic [BYTE_W-1:0] fbyte, fmod, mask;

  always_comb begin
    diff  = {1'b0, acc} - {1'b0, opnd};
    ndiff = {1'b0, acc[NIB_W-1:0]} - {1'b0, opnd[NIB_W-1:0]};
    mask  = '0;
    mask[bsel] = 1'b1;
    fbyte = '0;
    fbyte[FB_Z]  = fin.z;
    fbyte[FB_AC] = fin.ac;
    fbyte[FB_CY] = fin.cy;
    fmod  = (op == OP_FSET) ? (fbyte | mask) : (fbyte & ~mask);
    res   = '0;
    fout  = fin;
    wr    = 1'b0;
    unique case (op)
      OP_CMP: begin
        res  = diff[BYTE_W-1:0];
        fout = '{z: (diff[BYTE_W-1:0] == '0), ac: ndiff[NIB_W], cy: diff[BYTE_W]};
      end
      OP_INC: begin
        res = opnd + 1'b1;
        wr  = 1'b1;
        fout.z  = (res == '0);
        fout.ac = &opnd[NIB_W-1:0];
      end
      OP_DEC: begin
        res = opnd - 1'b1;
        wr  = 1'b1;
        fout.z  = (res == '0);
        fout.ac = ~|opnd[NIB_W-1:0];
      end
      OP_ROR:  begin res = {acc[0], acc[BYTE_W-1:1]};  fout.cy = acc[0];         wr = 1'b1; end
      OP_ROL:  begin res = {acc[BYTE_W-2:0], acc[BYTE_W-1]}; fout.cy = acc[BYTE_W-1]; wr = 1'b1; end
      OP_RORC: begin res = {fin.cy, acc[BYTE_W-1:1]};  fout.cy = acc[0];         wr = 1'b1; end
      OP_ROLC: begin res = {acc[BYTE_W-2:0], fin.cy};  fout.cy = acc[BYTE_W-1];  wr = 1'b1; end
      OP_BSET: begin res = opnd | mask;  wr = 1'b1; end
      OP_BCLR: begin res = opnd & ~mask; wr = 1'b1; end
      OP_FSET, OP_FCLR: begin
        res  = fmod;
        fout = '{z: fmod[FB_Z], ac: fmod[FB_AC], cy: fmod[FB_CY]};
      end
      OP_CSET: fout.cy = 1'b1;
      OP_CCLR: fout.cy = 1'b0;
      OP_CNOT: fout.cy = ~fin.cy;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc8_word_unit.sv
module acc8_word_unit
  import acc8_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] pair,
  input  logic [WORD_W-1:0] imm,
  input  flags_t            fin,
  output logic [WORD_W-1:0] res,
  output flags_t            fout,
  output logic              wr
);
  logic [WORD_W:0] sum, dif;
  logic [NIB_W:0]  nsum, ndif;

  always_comb begin
    sum  = {1'b0, pair} + {1'b0, imm};
    dif  = {1'b0, pair} - {1'b0, imm};
    nsum = {1'b0, pair[NIB_W-1:0]} + {1'b0, imm[NIB_W-1:0]};
    ndif = {1'b0, pair[NIB_W-1:0]} - {1'b0, imm[NIB_W-1:0]};
    res  = '0;
    fout = fin;
    wr   = 1'b0;
    unique case (op)
      OP_ADDW: begin
        res  = sum[WORD_W-1:0];
        wr   = 1'b1;
        fout = '{z: (sum[WORD_W-1:0] == '0), ac: nsum[NIB_W], cy: sum[WORD_W]};
      end
      OP_SUBW, OP_CMPW: begin
        res  = dif[WORD_W-1:0];
        wr   = (op == OP_SUBW);
        fout = '{z: (dif[WORD_W-1:0] == '0), ac: ndif[NIB_W], cy: dif[WORD_W]};
      end
      OP_INCW: begin res = pair + 1'b1; wr = 1'b1; end
      OP_DECW: begin res = pair - 1'b1; wr = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc8_flag_reg.sv
module acc8_flag_reg
  import acc8_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [OP_W-1:0]   op_code,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] opnd_in,
  input  logic [WORD_W-1:0] pair_in,
  input  logic [WORD_W-1:0] imm_in,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [BYTE_W-1:0] res_byte,
  output logic [WORD_W-1:0] res_word,
  output logic              wr_byte,
  output logic              wr_word,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_cy
);
  alu_op_e op;
  flags_t  cur, byte_f, word_f, nxt;
  logic    bwr, wwr;

  assign op = alu_op_e'(op_code);

  acc8_byte_unit u_byte (
    .op(op), .acc(acc_in), .opnd(opnd_in), .bsel(bit_sel), .fin(cur),
    .res(res_byte), .fout(byte_f), .wr(bwr)
  );

  acc8_word_unit u_word (
    .op(op), .pair(pair_in), .imm(imm_in), .fin(cur),
    .res(res_word), .fout(word_f), .wr(wwr)
  );

  assign nxt = is_word_op(op) ? word_f : byte_f;

  acc8_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .load(op_en), .d(nxt), .q(cur)
  );

  assign wr_byte = op_en & bwr;
  assign wr_word = op_en & wwr;
  assign flag_z  = cur.z;
  assign flag_ac = cur.ac;
  assign flag_cy = cur.cy;
endmodule

// File: rtl/acc8_alu_checker.sv
module acc8_alu_checker
  import acc8_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_en,
  input logic [OP_W-1:0]   op_code,
  input logic [BYTE_W-1:0] acc_in,
  input logic              wr_byte,
  input logic              wr_word,
  input logic              flag_z,
  input logic              flag_ac,
  input logic              flag_cy
);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable({flag_z, flag_ac, flag_cy}));

  assert_inc_keeps_cy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && (op_code == OP_INC || op_code == OP_DEC) |=> $stable(flag_cy));

  assert_ror_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op_code == OP_ROR |=> flag_cy == $past(acc_in[0]));

  assert_rot_keeps_z_ac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && (op_code inside {OP_ROR, OP_ROL, OP_RORC, OP_ROLC}) |=> $stable({flag_z, flag_ac}));

  assert_pair_no_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && (op_code == OP_INCW || op_code == OP_DECW) |=> $stable({flag_z, flag_ac, flag_cy}));

  assert_bit_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && (op_code == OP_BSET || op_code == OP_BCLR) |=> $stable({flag_z, flag_ac, flag_cy}));

  assert_cset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op_code == OP_CSET |=> flag_cy);

  assert_cnot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op_code == OP_CNOT |=> flag_cy != $past(flag_cy));

  assert_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_byte, wr_word}) && (op_en || !(wr_byte || wr_word)));
endmodule

bind acc8_alu acc8_alu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code), .acc_in(acc_in),
  .wr_byte(wr_byte), .wr_word(wr_word),
  .flag_z(flag_z), .flag_ac(flag_ac), .flag_cy(flag_cy)
);

// File: tb/acc8_alu_bench.sv
module acc8_alu_bench;
  import acc8_alu_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, op_en = 1'b0;
  logic [4:0]  op_code = '0;
  logic [7:0]  acc_in = '0, opnd_in = '0;
  logic [15:0] pair_in = '0, imm_in = '0;
  logic [2:0]  bit_sel = '0;
  logic [7:0]  res_byte;
  logic [15:0] res_word;
  logic wr_byte, wr_word, flag_z, flag_ac, flag_cy;
  logic [7:0]  cb;
  logic [15:0] cw;
  logic cwb, cww;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  acc8_alu u_acc8_alu (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input alu_op_e op, input logic [7:0] a, input logic [7:0] o,
                     input logic [15:0] p, input logic [15:0] im, input logic [2:0] b);
    @(negedge clk);
    op_code = op; acc_in = a; opnd_in = o; pair_in = p; imm_in = im; bit_sel = b;
    op_en = 1'b1;
    #1;
    cb = res_byte; cw = res_word; cwb = wr_byte; cww = wr_word;
    @(posedge clk);
    #1;
    op_en = 1'b0;
  endtask

  task automatic flags_are(input string req, input logic z, input logic ac, input logic cy);
    chk(req, {13'd0, flag_z, flag_ac, flag_cy}, {13'd0, z, ac, cy});
  endtask

  task automatic t_reset_idle;
    flags_are("R1 reset", 0, 0, 0);
    run(OP_CSET, 0, 0, 0, 0, 0);
    @(negedge clk); op_code = OP_CCLR; #1;
    chk("R12 idle strobes", {wr_byte, wr_word}, 2'b00);
    @(posedge clk); #1;
    flags_are("R1 idle hold", 0, 0, 1);
  endtask

  task automatic t_cmp;
    run(OP_CMP, 8'h35, 8'h35, 0, 0, 0);
    flags_are("R2 equal", 1, 0, 0);
    chk("R2 no write", {cwb, cww}, 2'b00);
    run(OP_CMP, 8'h10, 8'h01, 0, 0, 0);
    flags_are("R2 half borrow", 0, 1, 0);
    run(OP_CMP, 8'h01, 8'h02, 0, 0, 0);
    flags_are("R2 borrow", 0, 1, 1);
  endtask

  task automatic t_incdec;
    run(OP_CSET, 0, 0, 0, 0, 0);
    run(OP_INC, 0, 8'hFF, 0, 0, 0);
    chk("R3 inc wrap", {cwb, cb}, {1'b1, 8'h00});
    flags_are("R3 inc flags keep cy", 1, 1, 1);
    run(OP_CCLR, 0, 0, 0, 0, 0);
    run(OP_DEC, 0, 8'h10, 0, 0, 0);
    chk("R3 dec", cb, 8'h0F);
    flags_are("R3 dec flags", 0, 1, 0);
  endtask

  task automatic t_rot;
    run(OP_FSET, 0, 0, 0, 0, 3'd6);
    run(OP_ROR, 8'h01, 0, 0, 0, 0);
    chk("R4 ror", {cwb, cb}, {1'b1, 8'h80});
    flags_are("R4 ror flags", 1, 1, 1);
    run(OP_ROL, 8'h40, 0, 0, 0, 0);
    chk("R4 rol", cb, 8'h80);
    flags_are("R4 rol flags", 1, 1, 0);
    run(OP_CSET, 0, 0, 0, 0, 0);
    run(OP_RORC, 8'h02, 0, 0, 0, 0);
    chk("R5 rorc", cb, 8'h81);
    flags_are("R5 rorc flags", 1, 1, 0);
    run(OP_ROLC, 8'h80, 0, 0, 0, 0);
    chk("R5 rolc", cb, 8'h00);
    flags_are("R5 rolc flags", 1, 1, 1);
  endtask

  task automatic t_word;
    run(OP_ADDW, 0, 0, 16'hFFFF, 16'h0001, 0);
    chk("R6 addw", {cww, cw}, {1'b1, 16'h0000});
    flags_are("R6 addw flags", 1, 1, 1);
    run(OP_SUBW, 0, 0, 16'h1000, 16'h0001, 0);
    chk("R6 subw", cw, 16'h0FFF);
    flags_are("R6 subw flags", 0, 1, 0);
    run(OP_SUBW, 0, 0, 16'h0001, 16'h0002, 0);
    chk("R6 subw borrow", cw, 16'hFFFF);
    flags_are("R6 subw borrow flags", 0, 1, 1);
    run(OP_CMPW, 0, 0, 16'h1234, 16'h1234, 0);
    chk("R7 cmpw no write", {cwb, cww}, 2'b00);
    flags_are("R7 cmpw flags", 1, 0, 0);
  endtask

  task automatic t_pair;
    run(OP_CSET, 0, 0, 0, 0, 0);
    run(OP_INCW, 0, 0, 16'hFFFF, 0, 0);
    chk("R8 incw wrap", {cww, cw}, {1'b1, 16'h0000});
    run(OP_DECW, 0, 0, 16'h0000, 0, 0);
    chk("R8 decw wrap", cw, 16'hFFFF);
    flags_are("R8 flags kept", 1, 0, 1);
  endtask

  task automatic t_bits;
    run(OP_BSET, 0, 8'h00, 0, 0, 3'd7);
    chk("R9 bset", {cwb, cb}, {1'b1, 8'h80});
    run(OP_BCLR, 0, 8'hFF, 0, 0, 3'd0);
    chk("R9 bclr", cb, 8'hFE);
    flags_are("R9 flags kept", 1, 0, 1);
  endtask

  task automatic t_flagbyte;
    run(OP_FCLR, 0, 0, 0, 0, 3'd6);
    run(OP_FSET, 0, 0, 0, 0, 3'd4);
    flags_are("R10 set ac clr z", 0, 1, 1);
    run(OP_FSET, 0, 0, 0, 0, 3'd2);
    run(OP_FCLR, 0, 0, 0, 0, 3'd5);
    flags_are("R10 empty bits", 0, 1, 1);
    chk("R12 flag op no write", {cwb, cww}, 2'b00);
    run(OP_FCLR, 0, 0, 0, 0, 3'd0);
    flags_are("R10 clr cy", 0, 1, 0);
  endtask

  task automatic t_carry;
    run(OP_CNOT, 0, 0, 0, 0, 0);
    flags_are("R11 cnot", 0, 1, 1);
    run(OP_CNOT, 0, 0, 0, 0, 0);
    flags_are("R11 cnot back", 0, 1, 0);
    run(OP_CSET, 0, 0, 0, 0, 0);
    run(OP_CCLR, 0, 0, 0, 0, 0);
    flags_are("R11 cclr", 0, 1, 0);
  endtask

  initial begin
    fork
      begin
        #45 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset_idle();
        t_cmp();
        t_incdec();
        t_rot();
        t_word();
        t_pair();
        t_bits();
        t_flagbyte();
        t_carry();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule